// File: doc/BRIEF.md
# SD Host Command Path Controller

This block is the host side of the single-wire, bidirectional command line of an SD/SDIO-style card bus. A command (6-bit index, 32-bit argument and a set of per-command flags) enters through a valid/ready handshake. The controller serializes it as a 48-bit frame protected by CRC7. If a reply is requested, it then releases the line and waits for the card's start bit. It captures a 48-bit or 136-bit reply and checks the reply's CRC. The reply leaves the block through a second valid/ready handshake.

Optional behaviour is chosen per command:
- Holding the frame until the data path reports that its transfer has ended.
- Waiting without limit for the card's start bit, which it uses as an interrupt request.
- Waiting, after a good reply, for a device command-completion signal.

After every command the controller stays quiet for a minimum gap. Dropping the enable input returns it to idle from any state.

Back-pressure rules:
- The command source holds `cmd_valid` and all command fields steady until `cmd_ready` is seen high at a rising clock edge.
- `cmd_ready` is low while a reply is still waiting on the response port.
- `rsp_valid`, `rsp_data` and `rsp_crc_err` stay fixed until `rsp_ready` is high at a rising edge.

Top module: `sd_cmd_path`

## Requirements
- R1: After reset the controller is idle: `cmd_line_oe`=0, `cmd_line_o`=1, `rsp_valid`=0 and `cmd_ready`=0.
- R2: `cmd_ready` is high only when `en`=1, `rsp_valid`=0 and the controller has spent at least GAP_CYCLES (8) cycles in idle. It rises in the 8th cycle after reset release, and in the 8th cycle after the controller returns to idle.
- R3: A command accepted without the pend flag drives `cmd_line_oe`=1 for exactly 48 cycles, starting in the cycle after acceptance. During those cycles `cmd_line_o` carries, MSB first: 0, 1, index[5:0], argument[31:0], CRC7 and a final 1. The CRC7 uses polynomial x^7+x^3+1 with a zero start value and covers the first 40 bits.
- R4: With `cmd_pend`=1 the line stays released until `data_done` is high at a rising edge. The frame's start bit appears in the cycle after that edge.
- R5: With neither `cmd_rsp` nor `cmd_int` set, the controller returns to idle right after the frame. No reply is expected and no timeout is raised.
- R6: When a reply is expected, `cmd_line_i` is sampled in each of the TIMEOUT_CYCLES (64) cycles that follow the frame. A low level in any of those cycles, including the 64th, starts reception. If all 64 samples are high, `evt_timeout` pulses for one cycle, in the cycle right after the 64th, and no reply is delivered.
- R7: With `cmd_int`=1 there is no timeout. The controller waits for the start bit for as long as it takes.
- R8: A short reply is 48 bits including the start bit and is delivered in `rsp_data[47:0]` with the upper bits zero. A long reply (`cmd_long`=1) is 136 bits in `rsp_data[135:0]`. `rsp_crc_err`=1 when the received bits [7:1] differ from the CRC7 computed over bits [47:8] of a short reply or bits [127:8] of a long one.
- R9: With `cmd_nocrc`=1 the CRC comparison is skipped and `rsp_crc_err` is 0.
- R10: `rsp_valid` rises in the cycle after the last reply bit. It then holds, with `rsp_data` stable and `cmd_ready` low, until a rising edge with `rsp_ready`=1.
- R11: With `cmd_cpl`=1 and a reply without CRC error, the controller keeps `cmd_ready` low until `dev_cpl` is high at a rising edge. `evt_cpl` then pulses in the next cycle. A reply with a CRC error skips this wait.
- R12: `en`=0 at a rising edge puts the controller in idle. `cmd_line_oe` is 0 in the next cycle, and the command in flight delivers no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable; low forces idle |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_rsp | input | 1 | Expect a reply |
| cmd_long | input | 1 | Reply is 136 bits |
| cmd_nocrc | input | 1 | Skip reply CRC check |
| cmd_pend | input | 1 | Hold frame until data path done |
| cmd_int | input | 1 | Wait for start bit without timeout |
| cmd_cpl | input | 1 | Wait for device completion after reply |
| data_done | input | 1 | Data path transfer-end strobe |
| dev_cpl | input | 1 | Device command-completion signal |
| cmd_line_i | input | 1 | Command line level as received |
| cmd_line_o | output | 1 | Command line level driven |
| cmd_line_oe | output | 1 | Command line driver enable |
| rsp_valid | output | 1 | Reply available |
| rsp_ready | input | 1 | Reply consumer ready |
| rsp_data | output | 136 | Captured reply bits |
| rsp_crc_err | output | 1 | Reply CRC mismatch |
| evt_timeout | output | 1 | One-cycle reply timeout pulse |
| evt_cpl | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: an 8-cycle gap, a 64-cycle timeout, a 6-bit index, a 32-bit argument, and 48- and 136-bit replies. With these values a few hundred cycles reach the timeout edge from both sides (a start bit in the 64th sampled cycle, and silence through all 64). They also cover the exact cycle in which `cmd_ready` returns after each path through the controller, and full-length long replies with and without corrupted bits. A card model drives replies at chosen delays. Scoreboard queues compare every transmitted frame and every delivered reply against values the bench computes itself.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_CPL
  } state_t;

  typedef struct packed {
    logic rsp;
    logic lng;
    logic nocrc;
    logic pend;
    logic irq;
    logic cpl;
  } cmd_flags_t;

  // One serial step of CRC7, generator x^7 + x^3 + 1.
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    crc7_step = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/sdc_counter.sv
module sdc_counter #(
  parameter int MAX = 8,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  // Saturating up-counter, held at zero while clr is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (cnt != W'(MAX))   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sdc_tx.sv
module sdc_tx
  import sdc_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  localparam int PAY_W = 2 + IDX_W + ARG_W,
  localparam int N = PAY_W + 8,
  localparam int CW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             start,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             busy,
  output logic             line_o,
  output logic             last
);

  function automatic logic [6:0] crc_of(input logic [PAY_W-1:0] p);
    logic [6:0] c;
    c = '0;
    for (int i = PAY_W - 1; i >= 0; i--) c = crc7_step(c, p[i]);
    return c;
  endfunction

  logic [PAY_W-1:0] payload;
  logic [N-1:0]     frame;
  logic [N-1:0]     sh;
  logic [CW-1:0]    cnt;

  assign payload = {1'b0, 1'b1, idx, arg};
  assign frame   = {payload, crc_of(payload), 1'b1};
  assign last    = busy && (cnt == CW'(N - 1));
  assign line_o  = busy ? sh[N-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '0;
      cnt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      sh   <= frame;
      cnt  <= '0;
    end else if (busy) begin
      sh  <= {sh[N-2:0], 1'b0};
      cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  // R3: every frame opens with a low start bit
  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (busy && !line_o));
  // R3: the driver stays on until the last bit has gone out
  assert_frame_unbroken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && !abort && !start) |=> busy);
  // R3: the driver lets go right after the end bit
  assert_frame_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !abort && !start) |=> !busy);

endmodule

// File: rtl/sdc_rx.sv
module sdc_rx
  import sdc_pkg::*;
#(
  parameter int SHORT = 48,
  parameter int LONG = 136,
  parameter int LONG_SKIP = 8,
  localparam int CW = $clog2(LONG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort,
  input  logic            start,
  input  logic            lng,
  input  logic            din,
  output logic            done,
  output logic            crc_ok,
  output logic [LONG-1:0] data
);

  localparam logic [CW-1:0] LEN_S  = CW'(SHORT);
  localparam logic [CW-1:0] LEN_L  = CW'(LONG);
  localparam logic [CW-1:0] SKIP_L = CW'(LONG_SKIP);
  localparam logic [CW-1:0] END_S  = CW'(SHORT - 8);
  localparam logic [CW-1:0] END_L  = CW'(LONG - 8);

  logic            active;
  logic            lng_q;
  logic [CW-1:0]   cnt;
  logic [LONG-1:0] sh;
  logic [6:0]      crc;

  logic            take, mode, covered;
  logic [CW-1:0]   k, len, skip, cov_end;
  logic [6:0]      crc_base, crc_nxt;

  always_comb begin
    take     = (start || active) && !abort;
    k        = start ? '0 : cnt;
    mode     = start ? lng : lng_q;
    len      = mode ? LEN_L : LEN_S;
    skip     = mode ? SKIP_L : '0;
    cov_end  = mode ? END_L : END_S;
    covered  = (k >= skip) && (k < cov_end);
    crc_base = start ? 7'h00 : crc;
    crc_nxt  = covered ? crc7_step(crc_base, din) : crc_base;
  end

  assign done   = take && (k == len - 1'b1);
  assign crc_ok = (sh[6:0] == crc);
  assign data   = {sh[LONG-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      lng_q  <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      crc    <= '0;
    end else if (take) begin
      active <= !done;
      lng_q  <= mode;
      cnt    <= k + 1'b1;
      crc    <= crc_nxt;
      sh     <= start ? {{(LONG-1){1'b0}}, din} : {sh[LONG-2:0], din};
    end else begin
      active <= 1'b0;
    end
  end

  // R8: a finished reply is never followed by further sampling
  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);

endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path
  import sdc_pkg::*;
#(
  parameter int GAP_CYCLES = 8,
  parameter int TIMEOUT_CYCLES = 64,
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  parameter int SHORT_BITS = 48,
  parameter int LONG_BITS = 136
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [IDX_W-1:0]     cmd_index,
  input  logic [ARG_W-1:0]     cmd_arg,
  input  logic                 cmd_rsp,
  input  logic                 cmd_long,
  input  logic                 cmd_nocrc,
  input  logic                 cmd_pend,
  input  logic                 cmd_int,
  input  logic                 cmd_cpl,
  input  logic                 data_done,
  input  logic                 dev_cpl,
  input  logic                 cmd_line_i,
  output logic                 cmd_line_o,
  output logic                 cmd_line_oe,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [LONG_BITS-1:0] rsp_data,
  output logic                 rsp_crc_err,
  output logic                 evt_timeout,
  output logic                 evt_cpl
);

  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES);

  state_t             st, st_n;
  cmd_flags_t         fl, fl_in;
  logic [IDX_W-1:0]   idx_q;
  logic [ARG_W-1:0]   arg_q;
  logic [GAP_W-1:0]   gap_cnt;
  logic [TMR_W-1:0]   tmr_cnt;

  logic accept, tx_start, tx_busy, tx_last, tx_line;
  logic seen_start, time_up, want_rsp;
  logic rx_start, rx_done, rx_crc_ok, crc_bad;
  logic [LONG_BITS-1:0] rx_data;

  assign fl_in = '{rsp: cmd_rsp, lng: cmd_long, nocrc: cmd_nocrc,
                   pend: cmd_pend, irq: cmd_int, cpl: cmd_cpl};

  sdc_counter #(.MAX(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_IDLE), .cnt(gap_cnt));

  sdc_counter #(.MAX(TIMEOUT_CYCLES - 1)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_WAIT), .cnt(tmr_cnt));

  assign cmd_ready  = en && (st == ST_IDLE) && (gap_cnt == GAP_W'(GAP_CYCLES)) && !rsp_valid;
  assign accept     = cmd_valid && cmd_ready;
  assign want_rsp   = fl.rsp || fl.irq;
  assign seen_start = (st == ST_WAIT) && !cmd_line_i;
  assign time_up    = (st == ST_WAIT) && cmd_line_i && !fl.irq &&
                      (tmr_cnt == TMR_W'(TIMEOUT_CYCLES - 1));
  assign tx_start   = en && ((accept && !cmd_pend) || ((st == ST_PEND) && data_done));
  assign rx_start   = en && seen_start;
  assign crc_bad    = !fl.nocrc && !rx_crc_ok;

  sdc_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .abort(!en), .start(tx_start),
    .idx(accept ? cmd_index : idx_q), .arg(accept ? cmd_arg : arg_q),
    .busy(tx_busy), .line_o(tx_line), .last(tx_last));

  sdc_rx #(.SHORT(SHORT_BITS), .LONG(LONG_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .abort(!en), .start(rx_start), .lng(fl.lng),
    .din(cmd_line_i), .done(rx_done), .crc_ok(rx_crc_ok), .data(rx_data));

  assign cmd_line_o  = tx_line;
  assign cmd_line_oe = tx_busy;

  always_comb begin
    st_n = st;
    if (!en) st_n = ST_IDLE;
    else begin
      unique case (st)
        ST_IDLE: if (accept)     st_n = cmd_pend ? ST_PEND : ST_SEND;
        ST_PEND: if (data_done)  st_n = ST_SEND;
        ST_SEND: if (tx_last)    st_n = want_rsp ? ST_WAIT : ST_IDLE;
        ST_WAIT: if (seen_start) st_n = ST_RECV;
                 else if (time_up) st_n = ST_IDLE;
        ST_RECV: if (rx_done)    st_n = (crc_bad || !fl.cpl) ? ST_IDLE : ST_CPL;
        ST_CPL:  if (dev_cpl)    st_n = ST_IDLE;
        default:                 st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      fl          <= '0;
      idx_q       <= '0;
      arg_q       <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_crc_err <= 1'b0;
      evt_timeout <= 1'b0;
      evt_cpl     <= 1'b0;
    end else begin
      st          <= st_n;
      evt_timeout <= en && time_up;
      evt_cpl     <= en && (st == ST_CPL) && dev_cpl;
      if (accept) begin
        fl    <= fl_in;
        idx_q <= cmd_index;
        arg_q <= cmd_arg;
      end
      if (en && (st == ST_RECV) && rx_done) begin
        rsp_valid   <= 1'b1;
        rsp_data    <= rx_data;
        rsp_crc_err <= crc_bad;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R1: nothing is driven onto the line while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !cmd_line_oe);
  // R3: an immediate command starts its frame in the next cycle
  assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_pend) |=> (cmd_line_oe && !cmd_line_o));
  // R4: the line stays released while holding for the data path
  assert_pend_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PEND) |-> (!cmd_line_oe && fl.pend));
  // R6: the timeout event lasts a single cycle
  assert_timeout_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout |=> !evt_timeout);
  // R7: no timeout while waiting for an interrupt start bit
  assert_irq_no_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WAIT) && fl.irq) |=> !evt_timeout);
  // R10: a held reply does not change
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_crc_err)));
  // R10: no new command while a reply is pending
  assert_no_accept_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
  // R11: no new command while waiting for device completion
  assert_cpl_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CPL) |-> !cmd_ready);
  // R12: disabling stops the driver and returns to idle
  assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!cmd_line_oe && (st == ST_IDLE)));

endmodule

// File: tb/test_sd_cmd_path.sv
module test_sd_cmd_path;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [5:0] cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic cmd_rsp = 0, cmd_long = 0, cmd_nocrc = 0, cmd_pend = 0, cmd_int = 0, cmd_cpl = 0;
  logic data_done = 0, dev_cpl = 0;
  logic card_oe = 0, card_bit = 1;
  logic line_i, line_o, line_oe;
  logic rsp_valid, rsp_ready = 1'b1, rsp_crc_err;
  logic [135:0] rsp_data;
  logic evt_timeout, evt_cpl;

  assign line_i = card_oe ? card_bit : 1'b1;

  sd_cmd_path i_sd_cmd_path (
    .clk(clk), .rst_n(rst_n), .en(en), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_rsp(cmd_rsp), .cmd_long(cmd_long),
    .cmd_nocrc(cmd_nocrc), .cmd_pend(cmd_pend), .cmd_int(cmd_int), .cmd_cpl(cmd_cpl),
    .data_done(data_done), .dev_cpl(dev_cpl), .cmd_line_i(line_i), .cmd_line_o(line_o),
    .cmd_line_oe(line_oe), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_crc_err(rsp_crc_err), .evt_timeout(evt_timeout),
    .evt_cpl(evt_cpl));

  localparam logic [5:0] F_RSP = 6'b100000, F_LNG = 6'b010000, F_NOCRC = 6'b001000,
                         F_PEND = 6'b000100, F_INT = 6'b000010, F_CPL = 6'b000001;

  typedef struct {
    logic [135:0] d;
    logic         e;
    string        tag;
  } rsp_item_t;

  int n_chk = 0, n_fail = 0, to_cnt = 0;
  logic [47:0] frame_q[$];
  rsp_item_t   rsp_q[$];

  task automatic check(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Independent CRC7: shift left, feed back into taps 3 and 0.
  function automatic logic [6:0] crc7(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = '0;
    for (int i = hi; i >= lo; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_cmd(input logic [5:0] idx, input logic [31:0] arg);
    logic [135:0] v = '0;
    v[47:8] = {2'b01, idx, arg};
    v[7:0]  = {crc7(v, 47, 8), 1'b1};
    return v[47:0];
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] arg);
    logic [135:0] v = '0;
    v[47:8] = {2'b00, idx, arg};
    v[7:0]  = {crc7(v, 47, 8), 1'b1};
    return v;
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] body);
    logic [135:0] v;
    v[135:128] = 8'b0011_1111;
    v[127:8]   = body;
    v[7:0]     = {crc7(v, 127, 8), 1'b1};
    return v;
  endfunction

  // Frame scoreboard monitor
  int lm_cnt = 0;
  logic [47:0] lm_sh = '0, lm_exp;
  always @(negedge clk) if (rst_n) begin
    if (line_oe) begin
      lm_sh = {lm_sh[46:0], line_o};
      lm_cnt++;
      if (lm_cnt == 48) begin
        lm_cnt = 0;
        if (frame_q.size() == 0) check(0, "R3 unexpected frame", lm_sh, 0);
        else begin
          lm_exp = frame_q.pop_front();
          check(lm_sh == lm_exp, "R3 frame bits", lm_sh, lm_exp);
        end
      end
    end else lm_cnt = 0;
  end

  // Response scoreboard monitor
  rsp_item_t rm_exp;
  always @(negedge clk) if (rst_n && rsp_valid && rsp_ready) begin
    if (rsp_q.size() == 0) check(0, "R8 unexpected reply", rsp_data, 0);
    else begin
      rm_exp = rsp_q.pop_front();
      check(rsp_data == rm_exp.d, {rm_exp.tag, " reply data"}, rsp_data, rm_exp.d);
      check(rsp_crc_err == rm_exp.e, {rm_exp.tag, " crc flag"}, rsp_crc_err, rm_exp.e);
    end
  end

  always @(posedge clk) if (rst_n && evt_timeout) to_cnt++;

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [5:0] f, input bit push);
    @(negedge clk);
    cmd_index = idx; cmd_arg = arg;
    {cmd_rsp, cmd_long, cmd_nocrc, cmd_pend, cmd_int, cmd_cpl} = f;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    if (push) frame_q.push_back(mk_cmd(idx, arg));
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic frame_end;
    while (line_oe) @(negedge clk);
  endtask

  task automatic card_send(input logic [135:0] v, input int len, input int delay);
    repeat (delay) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      card_oe = 1'b1; card_bit = v[i];
      @(negedge clk);
    end
    card_oe = 1'b0; card_bit = 1'b1;
  endtask

  task automatic expect_rsp(input logic [135:0] d, input logic e, input string tag);
    rsp_item_t it;
    it.d = d; it.e = e; it.tag = tag;
    rsp_q.push_back(it);
  endtask

  initial begin
    logic [135:0] v;
    int to0;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(!line_oe && line_o && !rsp_valid && !cmd_ready, "R1 reset state",
          {line_oe, line_o, rsp_valid, cmd_ready}, 4'b0100);
    rst_n = 1'b1;
    repeat (7) @(negedge clk);
    check(cmd_ready == 0, "R2 ready before gap after reset", cmd_ready, 0);
    @(negedge clk);
    check(cmd_ready == 1, "R2 ready after gap after reset", cmd_ready, 1);

    // R5 command without reply
    issue(6'h00, 32'h0, 6'b0, 1);
    frame_end();
    repeat (7) @(negedge clk);
    check(cmd_ready == 0, "R2 gap after frame", cmd_ready, 0);
    @(negedge clk);
    check(cmd_ready == 1, "R5 idle right after frame", cmd_ready, 1);
    check(to_cnt == 0, "R5 no timeout", to_cnt, 0);

    // R8 short reply
    issue(6'h11, 32'hDEADBEEF, F_RSP, 1);
    frame_end();
    expect_rsp(mk_short(6'h11, 32'hCAFE0123), 0, "R8 short");
    card_send(mk_short(6'h11, 32'hCAFE0123), 48, 5);
    check(rsp_valid == 1, "R10 valid after last bit", rsp_valid, 1);

    // R6 start bit in the last sampled cycle
    issue(6'h2A, 32'h00000001, F_RSP, 1);
    frame_end();
    expect_rsp(mk_short(6'h2A, 32'h13572468), 0, "R6 late start");
    card_send(mk_short(6'h2A, 32'h13572468), 48, 63);

    // R6 timeout
    issue(6'h05, 32'h55AA55AA, F_RSP, 1);
    frame_end();
    to0 = to_cnt;
    repeat (63) @(negedge clk);
    check(evt_timeout == 0, "R6 no timeout at 63", evt_timeout, 0);
    @(negedge clk);
    check(evt_timeout == 1, "R6 timeout pulse", evt_timeout, 1);
    @(negedge clk);
    check(evt_timeout == 0 && !rsp_valid, "R6 pulse ends, no reply", {evt_timeout, rsp_valid}, 0);

    // R7 interrupt wait
    to0 = to_cnt;
    issue(6'h28, 32'h0, F_RSP | F_INT, 1);
    frame_end();
    expect_rsp(mk_short(6'h28, 32'h0000BEEF), 0, "R7 irq reply");
    card_send(mk_short(6'h28, 32'h0000BEEF), 48, 100);
    check(to_cnt == to0, "R7 no timeout while waiting", to_cnt, to0);

    // R8 CRC error on short reply
    issue(6'h0D, 32'h12345678, F_RSP, 1);
    frame_end();
    v = mk_short(6'h0D, 32'h0) ^ 136'h4;
    expect_rsp(v, 1, "R8 bad crc");
    card_send(v, 48, 2);

    // R9 CRC check skipped
    issue(6'h29, 32'h00FF0000, F_RSP | F_NOCRC, 1);
    frame_end();
    v = mk_short(6'h3F, 32'hFFFFFFFF) ^ 136'h10;
    expect_rsp(v, 0, "R9 nocrc");
    card_send(v, 48, 1);

    // R8 long replies
    issue(6'h02, 32'h0, F_RSP | F_LNG, 1);
    frame_end();
    v = mk_long({32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C, 24'h4B5A69});
    expect_rsp(v, 0, "R8 long");
    card_send(v, 136, 3);
    issue(6'h09, 32'hA5A5A5A5, F_RSP | F_LNG, 1);
    frame_end();
    v = mk_long({32'hFEDCBA98, 32'h76543210, 32'h11111111, 24'h222222}) ^ (136'h1 << 60);
    expect_rsp(v, 1, "R8 long bad crc");
    card_send(v, 136, 0);

    // R4 pend on data path
    issue(6'h0C, 32'h0BADF00D, F_PEND, 1);
    for (int i = 0; i < 10; i++) begin
      if (i == 0 || i == 9) check(line_oe == 0, "R4 line released while pending", line_oe, 0);
      @(negedge clk);
    end
    data_done = 1'b1;
    @(negedge clk);
    data_done = 1'b0;
    check(line_oe == 1 && line_o == 0, "R4 start bit after data done", {line_oe, line_o}, 2'b10);
    frame_end();

    // R10 back-pressure on reply
    rsp_ready = 1'b0;
    issue(6'h07, 32'h77777777, F_RSP, 1);
    frame_end();
    v = mk_short(6'h07, 32'h87654321);
    expect_rsp(v, 0, "R10 held reply");
    card_send(v, 48, 4);
    repeat (5) @(negedge clk);
    check(rsp_valid && rsp_data == v && !cmd_ready, "R10 reply held, ready low",
          {rsp_valid, cmd_ready}, 2'b10);
    rsp_ready = 1'b1;
    @(negedge clk);

    // R11 device completion wait
    issue(6'h3C, 32'h00000010, F_RSP | F_CPL, 1);
    frame_end();
    v = mk_short(6'h3C, 32'h00000020);
    expect_rsp(v, 0, "R11 cpl reply");
    card_send(v, 48, 2);
    repeat (12) @(negedge clk);
    check(cmd_ready == 0, "R11 ready held during completion wait", cmd_ready, 0);
    dev_cpl = 1'b1;
    @(negedge clk);
    dev_cpl = 1'b0;
    check(evt_cpl == 1, "R11 completion pulse", evt_cpl, 1);
    issue(6'h3C, 32'h00000011, F_RSP | F_CPL, 1);
    frame_end();
    v = mk_short(6'h3C, 32'h0) ^ 136'h2;
    expect_rsp(v, 1, "R11 bad crc skips wait");
    card_send(v, 48, 2);
    repeat (9) @(negedge clk);
    check(cmd_ready == 1, "R11 crc error returns to idle", cmd_ready, 1);

    // R12 abort mid-frame
    to0 = to_cnt;
    issue(6'h01, 32'hFFFF0000, F_RSP, 0);
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(line_oe == 0 && cmd_ready == 0, "R12 driver off after disable", {line_oe, cmd_ready}, 0);
    en = 1'b1;
    repeat (80) @(negedge clk);
    check(!rsp_valid && to_cnt == to0 && cmd_ready, "R12 no reply after abort",
          {rsp_valid, cmd_ready}, 2'b01);

    repeat (4) @(negedge clk);
    check(frame_q.size() == 0, "R3 all frames seen", frame_q.size(), 0);
    check(rsp_q.size() == 0, "R8 all replies seen", rsp_q.size(), 0);
    summary();
  end

endmodule